// File: doc/BRIEF.md
# Step/Direction Microstepping Indexer

This block keeps the electrical angle of a two-phase bipolar stepper motor as one of 128 equally spaced positions per electrical cycle. Each rising edge on the step input moves the position by one move of the selected resolution. The direction input picks forward or reverse travel. From the position it derives a signed current level for each of the two windings, in percent of full scale. Winding A follows the cosine of the angle and winding B follows the sine. A current-chopping stage downstream turns these levels into reference voltages.

A three-bit mode input picks full, half, quarter, eighth, sixteenth or thirty-second stepping. Every mode walks the same 128-entry wave, using a coarser stride. Full step sits on the four 45-degree diagonals, so both windings carry 71 percent. Changing the mode while the motor turns does not reset the position. The next step instead lands on the nearest state in the step direction that is legal for the new mode.

Two more outputs serve the decay logic and the supervisor. A per-winding flag marks when that winding's magnitude is falling for the current direction of travel. An active-low home output marks the 45-degree rest position. A synchronous reset returns the indexer to that position. An active-high enable from the supervisor decides whether step edges are acted on.

Top module: `ustep_indexer`

## Requirements
- R1: A synchronous active-low reset places the indexer at position 16 (45 degrees), where cur_a = +71, cur_b = +71 and home_n = 0. The last direction resets to forward (1).
- R2: In the 1/32 modes (mode_in = 101, 110 or 111), each accepted rising step edge moves the position by +1 modulo 128 when dir_in = 1, and by -1 modulo 128 when dir_in = 0.
- R3: For position p, cur_b = round(100·sin(2πp/128)) and cur_a = round(100·cos(2πp/128)). Both are signed two's-complement 8-bit values in percent. A zero level is never negative, and the two levels are never both zero.
- R4: Modes 001, 010, 011 and 100 (half, quarter, 1/8, 1/16) use strides of 16, 8, 4 and 2 positions. A step moves to the next multiple of the stride in the step direction.
- R5: Mode 000 (full step) visits only positions with p mod 32 = 16 (45, 135, 225 and 315 degrees). After a full step, both levels have magnitude 71.
- R6: When the mode changes between steps, the next step moves to the nearest position legal for the new mode, strictly beyond the current one in the step direction. The position is not reset.
- R7: home_n is 0 exactly when the position is 16, and 1 otherwise.
- R8: While en = 0, rising step edges are ignored and the position holds. A step level already high when en returns to 1 does not cause a step.
- R9: Step and direction each pass through a two-flop synchroniser and an edge detector. The outputs change after the third rising clock edge that samples step_in high. A step level held high gives exactly one step.
- R10: fall_b = 1 when bit 5 of the position equals the direction of the last accepted step (1 = forward), otherwise 0. fall_a is the inverse of fall_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset to the home position |
| en | input | 1 | Active-high enable; step edges are ignored while low |
| step_in | input | 1 | Asynchronous step request; each rising edge is one move |
| dir_in | input | 1 | Asynchronous direction; 1 = forward, 0 = reverse |
| mode_in | input | 3 | Step resolution select; must be stable around a step |
| cur_a | output | 8 | Signed winding A level in percent (cosine) |
| cur_b | output | 8 | Signed winding B level in percent (sine) |
| fall_a | output | 1 | Winding A magnitude is falling for the last direction |
| fall_b | output | 1 | Winding B magnitude is falling for the last direction |
| home_n | output | 1 | Low while the indexer sits at the 45-degree home position |

## Verification
The bench builds the indexer with its default two-stage synchroniser. This makes the three-edge step latency fixed and checkable to the exact cycle. With the 128-position cycle kept whole, one forward sweep in 1/32 mode reaches every table entry and every sign change of both windings. The coarse modes, the wrap through position 0, and the re-alignment after mode changes are all exercised, each from an off-grid starting point. The disabled-edge case, including a step level that is still high when enable returns, is also within reach.

// File: rtl/ustep_pkg.sv
// ustep_pkg: shared sizes, types and the quarter-wave magnitude table
// of the microstepping indexer. Assumes a 128-position electrical
// cycle split into four 32-position quarters.
package ustep_pkg;

    localparam int POS_W  = 7;                  // position bits
    localparam int QTR_W  = 5;                  // bits inside one quarter
    localparam int QUAD_W = POS_W - QTR_W;      // quarter number bits
    localparam int QTR_N  = 1 << QTR_W;         // positions per quarter
    localparam int IDX_W  = QTR_W + 1;          // folded index 0..QTR_N
    localparam int MAG_W  = 7;                  // magnitude 0..100
    localparam int LVL_W  = MAG_W + 1;          // signed level
    localparam int MODE_W = 3;                  // resolution select

    typedef logic [POS_W-1:0]        pos_t;
    typedef logic signed [LVL_W-1:0] lvl_t;
    typedef logic [MAG_W-1:0]        mag_t;

    localparam logic [MODE_W-1:0] MODE_FULL = '0;
    localparam logic [QTR_W-1:0]  ANCHOR_Q  = QTR_W'(QTR_N / 2);
    localparam pos_t              HOME_POS  = pos_t'(QTR_N / 2);

    // Magnitude in percent of sin(90deg * k / 32), rounded.
    function automatic mag_t quarter_mag(input logic [IDX_W-1:0] k);
        case (k)
            6'd0:  return 7'd0;
            6'd1:  return 7'd5;
            6'd2:  return 7'd10;
            6'd3:  return 7'd15;
            6'd4:  return 7'd20;
            6'd5:  return 7'd24;
            6'd6:  return 7'd29;
            6'd7:  return 7'd34;
            6'd8:  return 7'd38;
            6'd9:  return 7'd43;
            6'd10: return 7'd47;
            6'd11: return 7'd51;
            6'd12: return 7'd56;
            6'd13: return 7'd60;
            6'd14: return 7'd63;
            6'd15: return 7'd67;
            6'd16: return 7'd71;
            6'd17: return 7'd74;
            6'd18: return 7'd77;
            6'd19: return 7'd80;
            6'd20: return 7'd83;
            6'd21: return 7'd86;
            6'd22: return 7'd88;
            6'd23: return 7'd90;
            6'd24: return 7'd92;
            6'd25: return 7'd94;
            6'd26: return 7'd96;
            6'd27: return 7'd97;
            6'd28: return 7'd98;
            6'd29: return 7'd99;
            6'd30: return 7'd100;
            6'd31: return 7'd100;
            6'd32: return 7'd100;
            default: return 7'd0;
        endcase
    endfunction

    // Log2 of the stride for the fine modes; codes past 1/32 saturate.
    function automatic int stride_shift(input logic [MODE_W-1:0] m);
        if (m >= MODE_W'(QTR_W))
            return 0;
        return QTR_W - int'(m);
    endfunction

endpackage

// File: rtl/ustep_sync.sv
// ustep_sync: brings the step and direction levels into the clock
// domain through STAGES flops each, and detects the rising step edge.
// Assumes STAGES >= 1. Flops reset high, so a step level that is
// already high when reset ends produces no edge.
module ustep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_raw,
    input  logic dir_raw,
    output logic step_rise,
    output logic dir_s
);
    localparam int LANES = 2;

    logic [LANES-1:0] lane_in;
    logic [LANES-1:0] lane_out;
    logic             step_prev;

    assign lane_in = {dir_raw, step_raw};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [STAGES-1:0] sh_q;
        // Shift the raw level through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q <= '1;
            end else begin
                for (int i = STAGES - 1; i > 0; i--)
                    sh_q[i] <= sh_q[i-1];
                sh_q[0] <= lane_in[l];
            end
        end
        assign lane_out[l] = sh_q[STAGES-1];
    end

    // Remember the previous synchronised step level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_prev <= 1'b1;
        else
            step_prev <= lane_out[0];
    end

    assign step_rise = lane_out[0] & ~step_prev;
    assign dir_s     = lane_out[1];

endmodule

// File: rtl/ustep_position.sv
// ustep_position: the 7-bit electrical position register and its
// next-state arithmetic for every resolution. A step lands on the next
// legal state for the present mode in the step direction, so a mode
// change re-aligns instead of resetting. Also keeps the last direction.
module ustep_position
    import ustep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              dir_fwd,
    input  logic [MODE_W-1:0] mode,
    output pos_t              pos,
    output logic              dir_last
);
    pos_t                pos_nxt;
    pos_t                stride;
    pos_t                mask;
    pos_t                base;
    logic [QUAD_W-1:0]   quad;
    logic [QTR_W-1:0]    offs;

    assign quad = pos[POS_W-1:QTR_W];
    assign offs = pos[QTR_W-1:0];

    // Work out the next legal position for the selected mode and direction.
    always_comb begin
        stride = pos_t'(1) << stride_shift(mode);
        mask   = stride - pos_t'(1);
        base   = pos & ~mask;
        if (mode == MODE_FULL) begin
            if (dir_fwd)
                pos_nxt = (offs < ANCHOR_Q) ? {quad, ANCHOR_Q}
                                            : {quad + QUAD_W'(1), ANCHOR_Q};
            else
                pos_nxt = (offs > ANCHOR_Q) ? {quad, ANCHOR_Q}
                                            : {quad - QUAD_W'(1), ANCHOR_Q};
        end else begin
            if (dir_fwd)
                pos_nxt = base + stride;
            else
                pos_nxt = (pos == base) ? pos - stride : base;
        end
    end

    // Hold the position and last direction; move only on an accepted step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos      <= HOME_POS;
            dir_last <= 1'b1;
        end else if (adv) begin
            pos      <= pos_nxt;
            dir_last <= dir_fwd;
        end
    end

endmodule

// File: rtl/ustep_wave.sv
// ustep_wave: turns a position into a signed level of sin(angle + the
// PHASE_OFS positions). Folds the phase into the quarter-wave table and
// takes the sign from the half-cycle bit. Purely combinational.
module ustep_wave
    import ustep_pkg::*;
#(
    parameter int PHASE_OFS = 0
) (
    input  pos_t pos,
    output lvl_t lvl
);
    pos_t             ph;
    logic [IDX_W-1:0] idx;
    mag_t             mag;

    // Fold the shifted phase onto the first quarter and look up the magnitude.
    always_comb begin
        ph  = pos + pos_t'(PHASE_OFS);
        idx = ph[QTR_W] ? IDX_W'(QTR_N) - {1'b0, ph[QTR_W-1:0]}
                        : {1'b0, ph[QTR_W-1:0]};
        mag = quarter_mag(idx);
        lvl = ph[POS_W-1] ? -lvl_t'(mag) : lvl_t'(mag);
    end

endmodule

// File: rtl/ustep_indexer.sv
// ustep_indexer: step/direction microstepping indexer for a two-phase
// bipolar stepper. Synchronises the inputs, steps a 128-position
// electrical angle at the selected resolution, and drives the cosine
// (A) and sine (B) winding levels, falling flags and a home marker.
// Assumes mode_in is stable around each step edge.
module ustep_indexer
    import ustep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              step_in,
    input  logic              dir_in,
    input  logic [MODE_W-1:0] mode_in,
    output lvl_t              cur_a,
    output lvl_t              cur_b,
    output logic              fall_a,
    output logic              fall_b,
    output logic              home_n
);
    localparam int WINDINGS = 2;

    logic step_rise;
    logic dir_s;
    logic adv;
    logic dir_last;
    pos_t pos;
    lvl_t lvls [WINDINGS];

    ustep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_raw  (step_in),
        .dir_raw   (dir_in),
        .step_rise (step_rise),
        .dir_s     (dir_s)
    );

    assign adv = step_rise & en;

    ustep_position u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .dir_fwd  (dir_s),
        .mode     (mode_in),
        .pos      (pos),
        .dir_last (dir_last)
    );

    // Winding 0 is the sine (B); winding 1 leads by a quarter (A, cosine).
    for (genvar w = 0; w < WINDINGS; w++) begin : g_wind
        ustep_wave #(.PHASE_OFS(w * QTR_N)) u_wave (
            .pos (pos),
            .lvl (lvls[w])
        );
    end

    assign cur_b  = lvls[0];
    assign cur_a  = lvls[1];
    assign fall_b = (pos[QTR_W] == dir_last);
    assign fall_a = ~fall_b;
    assign home_n = (pos != HOME_POS);

endmodule

// File: rtl/ustep_indexer_chk.sv
// ustep_indexer_chk: property checker for ustep_indexer, bound to every
// instance of the top module.
module ustep_indexer_chk
    import ustep_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              adv,
    input pos_t              pos,
    input logic [MODE_W-1:0] mode_in,
    input lvl_t              cur_a,
    input lvl_t              cur_b,
    input logic              home_n
);
    // R1
    reset_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!home_n && cur_a == 8'sd71 && cur_b == 8'sd71));

    // R7
    home_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !home_n |-> (cur_a == 8'sd71 && cur_b == 8'sd71));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pos));

    // R2
    fine_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && mode_in >= 3'd5) |=>
            (pos == $past(pos) + 7'd1) || (pos == $past(pos) - 7'd1));

    // R4
    half_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && mode_in == 3'd1) |=> (pos[3:0] == 4'd0));

    // R5
    full_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && mode_in == 3'd0) |=>
            ((cur_a == 8'sd71 || cur_a == -8'sd71) &&
             (cur_b == 8'sd71 || cur_b == -8'sd71)));

    // R3
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_a != 8'sd0) || (cur_b != 8'sd0));

endmodule

bind ustep_indexer ustep_indexer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .adv     (adv),
    .pos     (pos),
    .mode_in (mode_in),
    .cur_a   (cur_a),
    .cur_b   (cur_b),
    .home_n  (home_n)
);

// File: tb/ustep_indexer_test.sv
// ustep_indexer_test: scoreboard bench. Driver tasks update a position
// model and push expected outputs; a monitor pops and compares them.
module ustep_indexer_test;
    import ustep_pkg::*;

    logic       clk     = 1'b0;
    logic       rst_n   = 1'b0;
    logic       en      = 1'b1;
    logic       step_in = 1'b0;
    logic       dir_in  = 1'b1;
    logic [2:0] mode_in = 3'd5;
    lvl_t       cur_a;
    lvl_t       cur_b;
    logic       fall_a;
    logic       fall_b;
    logic       home_n;

    always #4 clk = ~clk;

    ustep_indexer #(.SYNC_STAGES(2)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .step_in (step_in),
        .dir_in  (dir_in),
        .mode_in (mode_in),
        .cur_a   (cur_a),
        .cur_b   (cur_b),
        .fall_a  (fall_a),
        .fall_b  (fall_b),
        .home_n  (home_n)
    );

    typedef struct {
        int    a;
        int    b;
        bit    hn;
        bit    fa;
        bit    fb;
        string req;
    } exp_t;

    exp_t sb_q[$];
    event mon_ev;
    int   checks = 0;
    int   errors = 0;
    int   m_pos  = 16;
    bit   m_fwd  = 1'b1;
    bit   done   = 1'b0;

    function automatic bit valid_pos(int p, int md);
        int stride;
        if (md == 0) return (p % 32) == 16;
        stride = (md >= 5) ? 1 : (1 << (5 - md));
        return (p % stride) == 0;
    endfunction

    // Model: search outward for the next legal position in the direction.
    function automatic int next_pos(int p, bit fwd, int md);
        for (int k = 1; k <= 128; k++) begin
            int c;
            c = fwd ? (p + k) % 128 : (p - k + 128) % 128;
            if (valid_pos(c, md)) return c;
        end
        return p;
    endfunction

    function automatic int pct(int p);
        real x;
        int  m;
        x = $sin(6.283185307179586 * real'(p) / 128.0);
        m = $rtoi(((x < 0.0) ? -x : x) * 100.0 + 0.5);
        return (x < 0.0) ? -m : m;
    endfunction

    task automatic check_int(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_expect(string req);
        exp_t e;
        e.b   = pct(m_pos);
        e.a   = pct(m_pos + 32);
        e.hn  = (m_pos != 16);
        e.fb  = (((m_pos >> 5) & 1) == int'(m_fwd));
        e.fa  = !e.fb;
        e.req = req;
        sb_q.push_back(e);
        -> mon_ev;
    endtask

    // Monitor: compare every queued expectation against the outputs.
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check_int(e.req, "cur_a", int'(cur_a), e.a);
                check_int(e.req, "cur_b", int'(cur_b), e.b);
                check_int(e.req, "home_n", int'(home_n), int'(e.hn));
                check_int(e.req, "fall_a", int'(fall_a), int'(e.fa));
                check_int(e.req, "fall_b", int'(fall_b), int'(e.fb));
            end
        end
    end

    task automatic do_step(bit fwd, int md, string req);
        @(negedge clk);
        dir_in  = fwd;
        mode_in = 3'(md);
        step_in = 1'b1;
        repeat (4) @(negedge clk);
        step_in = 1'b0;
        repeat (3) @(negedge clk);
        if (en) begin
            m_pos = next_pos(m_pos, fwd, md);
            m_fwd = fwd;
        end
        push_expect(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pos = 16;
        m_fwd = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push_expect("R1 R7 R10 reset");

        // R2 fine stepping forward and back, R10 flags follow direction
        for (int i = 0; i < 3; i++) do_step(1'b1, 5, "R2 R3 R10 fwd");
        for (int i = 0; i < 5; i++) do_step(1'b0, 6, "R2 R3 R10 rev");

        // R4 R6 coarse modes and re-alignment from off-grid positions
        do_step(1'b1, 3, "R4 R6 R7 eighth realign to home");
        do_step(1'b1, 3, "R4 eighth fwd");
        do_step(1'b0, 4, "R4 R6 sixteenth rev");
        do_step(1'b1, 1, "R4 R6 half realign");
        do_step(1'b1, 1, "R4 R3 half fwd");
        do_step(1'b0, 2, "R4 R6 quarter rev");

        // R5 full step with wrap in both directions
        do_step(1'b1, 0, "R5 R6 full realign");
        for (int i = 0; i < 3; i++) do_step(1'b1, 0, "R5 full fwd");
        do_step(1'b0, 0, "R5 full rev wrap");
        do_step(1'b1, 0, "R5 full fwd wrap");

        // R8 edges while disabled, and a level held across re-enable
        en = 1'b0;
        do_step(1'b1, 5, "R8 disabled step");
        @(negedge clk);
        step_in = 1'b1;
        repeat (4) @(negedge clk);
        en = 1'b1;
        repeat (4) @(negedge clk);
        step_in = 1'b0;
        repeat (3) @(negedge clk);
        push_expect("R8 held level at enable");
        do_step(1'b1, 5, "R8 after enable");

        // R3 full forward sweep, then 1/32 reverse wrap through zero
        for (int i = 0; i < 128; i++) do_step(1'b1, 7, "R3 R2 sweep");
        while (m_pos != 1) do_step(1'b0, 5, "R2 rev approach");
        for (int i = 0; i < 3; i++) do_step(1'b0, 5, "R2 R3 rev wrap");

        // R1 reset mid-run returns home
        do_reset();
        push_expect("R1 mid-run reset");

        // R9 latency counted in clock edges, and a held level steps once
        @(negedge clk);
        dir_in  = 1'b1;
        mode_in = 3'd5;
        step_in = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        check_int("R9", "cur_b after 2 edges", int'(cur_b), pct(16));
        @(posedge clk);
        #1;
        check_int("R9", "cur_b after 3 edges", int'(cur_b), pct(17));
        repeat (20) @(negedge clk);
        check_int("R9", "cur_b held high", int'(cur_b), pct(17));
        step_in = 1'b0;
        m_pos   = 17;
        repeat (3) @(negedge clk);
        push_expect("R9 single step");

        repeat (5) @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule